// File: doc/BRIEF.md
# BCD Adjust Unit

An execution unit that applies the six decimal-correction operations to an 8-bit accumulator pair: a low byte (AL) and a high byte (AH). Two packed corrections repair AL after a binary add or subtract of two-digit BCD values. Two unpacked corrections repair AL and AH after an add or subtract of single-digit values. A multiply-side correction splits AL into quotient and remainder by an 8-bit immediate base. A divide-side correction folds AH and AL into one byte by multiplying AH by the base.

The caller presents the operands, the incoming AF and CF flags, a 3-bit operation code and the base, and raises `start_i` for one cycle. Results appear with a one-cycle `done_o` pulse and stay held until the next completion. The new flags come with a valid mask. Flags outside the mask read as zero. The split-by-base operation runs an iterative divider and holds `busy_o` high while it works. A start request made while busy is ignored.

Top module: `bcd_adjust_unit`

## Requirements
- R1: After reset, done_o, busy_o and div_err_o are 0, al_o and ah_o are 0x00, and flags_vld_o is 0.
- R2: Operation codes are 0 packed-add correction, 1 packed-subtract correction, 2 unpacked-add correction, 3 unpacked-subtract correction, 4 split by base, 5 fold by base, 6 and 7 reserved. Flag bit positions in flags_o and flags_vld_o are 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF. A start accepted with any code other than 4 (or with code 4 and base 0) raises done_o on the next clock edge.
- R3: Packed-add correction: if AL[3:0] > 9 or AF=1, then AL += 6 (mod 256) and AF=1, else AF=0. Then, if that AL > 0x9F or the incoming CF=1, AL += 0x60 and CF=1, else CF=0. SF and ZF come from the final AL. Valid: CF, AF, ZF, SF. AH is unchanged.
- R4: Packed-subtract correction: the same two steps with subtraction of 6 and 0x60 (mod 256). Valid: CF, AF. AH is unchanged.
- R5: Unpacked-add correction: if AF=1 or AL[3:0] > 9, then AL becomes (AL+6) & 0x0F, AH += 1, and AF=CF=1. Otherwise AL becomes AL & 0x0F and AF=CF=0. Valid: CF, AF.
- R6: Unpacked-subtract correction: if AL[3:0] > 9 or AF=1, then AH decrements by 1, and by 2 if the original AL < 6. AL becomes (AL-6) & 0x0F and AF=CF=1. Otherwise AL becomes AL & 0x0F and AF=CF=0. Valid: CF, AF.
- R7: Split by base (nonzero base): AH = AL / base and AL = AL mod base. SF, ZF and PF come from the new AL. Valid: PF, ZF, SF. done_o arrives within 10 cycles of the start.
- R8: Split with base 0: div_err_o=1 at completion, al_o and ah_o equal the inputs, and flags_vld_o is 0.
- R9: Fold by base: the sum S = AH*base + AL (16 bit). AL = S[7:0] and AH = 0. CF = (S > 0xFF). AF = 1 when bit 3 of AH*base differs from bit 3 of S.
- R10: Fold by base: OF = new AL[7] XOR old AL[7]. SF, ZF and PF come from the new AL. All six flags are valid.
- R11: PF is 1 when its byte has an even number of set bits. At completion, every flags_o bit outside flags_vld_o is 0. Reserved codes pass AL and AH through with an empty mask.
- R12: start_i is ignored while busy_o is 1. No extra completion results, and the pending result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request, one cycle |
| op_i | input | 3 | Operation code |
| al_i | input | 8 | Low accumulator byte |
| ah_i | input | 8 | High accumulator byte |
| af_i | input | 1 | Incoming adjust flag |
| cf_i | input | 1 | Incoming carry flag |
| base_i | input | 8 | Immediate base |
| busy_o | output | 1 | Divider in progress, start ignored |
| done_o | output | 1 | Result valid pulse |
| al_o | output | 8 | Result low byte |
| ah_o | output | 8 | Result high byte |
| flags_o | output | 6 | Result flags |
| flags_vld_o | output | 6 | Mask of flags written by the operation |
| div_err_o | output | 1 | Zero base on a split |

## Verification
The assertions assume that the operands stay stable from the start edge until a non-divide result is captured. The divider takes its own copy of the operands, so it does not depend on this. They also assume that start_i is never X while out of reset. The bench changes inputs only on falling edges and keeps each request for exactly one cycle. It waits for busy_o to fall before issuing the next request. The only exception is a deliberate start pulse during a split, which exercises R12.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_N = 6;
  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_AF = 2;
  localparam int F_ZF = 3;
  localparam int F_SF = 4;
  localparam int F_OF = 5;

  typedef enum logic [2:0] {
    OP_PK_ADD  = 3'd0,
    OP_PK_SUB  = 3'd1,
    OP_UP_ADD  = 3'd2,
    OP_UP_SUB  = 3'd3,
    OP_SPLIT   = 3'd4,
    OP_FOLD    = 3'd5
  } bcd_op_e;

  function automatic logic even_par(input logic [BYTE_W-1:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/bcd_adjust_core.sv
module bcd_adjust_core
  import bcd_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [BYTE_W-1:0] al_i,
  input  logic [BYTE_W-1:0] ah_i,
  input  logic              af_i,
  input  logic              cf_i,
  input  logic [BYTE_W-1:0] base_i,
  output logic [BYTE_W-1:0] al_o,
  output logic [BYTE_W-1:0] ah_o,
  output logic [FLAG_N-1:0] flags_o,
  output logic [FLAG_N-1:0] vld_o
);
  logic              nib_fix, hi_fix;
  logic [BYTE_W-1:0] step1, step2;
  logic [2*BYTE_W-1:0] prod, sum;

  always_comb begin
    al_o    = al_i;
    ah_o    = ah_i;
    flags_o = '0;
    vld_o   = '0;
    nib_fix = (al_i[3:0] > 4'd9) | af_i;
    step1   = al_i;
    step2   = al_i;
    hi_fix  = 1'b0;
    prod    = 16'(ah_i) * 16'(base_i);
    sum     = prod + 16'(al_i);
    case (op_i)
      OP_PK_ADD, OP_PK_SUB: begin
        if (op_i == OP_PK_ADD) begin
          step1  = nib_fix ? al_i + 8'h06 : al_i;
          hi_fix = (step1 > 8'h9F) | cf_i;
          step2  = hi_fix ? step1 + 8'h60 : step1;
        end else begin
          step1  = nib_fix ? al_i - 8'h06 : al_i;
          hi_fix = (step1 > 8'h9F) | cf_i;
          step2  = hi_fix ? step1 - 8'h60 : step1;
        end
        al_o           = step2;
        flags_o[F_AF]  = nib_fix;
        flags_o[F_CF]  = hi_fix;
        vld_o[F_AF]    = 1'b1;
        vld_o[F_CF]    = 1'b1;
        if (op_i == OP_PK_ADD) begin
          flags_o[F_SF] = step2[7];
          flags_o[F_ZF] = (step2 == '0);
          vld_o[F_SF]   = 1'b1;
          vld_o[F_ZF]   = 1'b1;
        end
      end
      OP_UP_ADD: begin
        al_o          = nib_fix ? ((al_i + 8'h06) & 8'h0F) : (al_i & 8'h0F);
        ah_o          = nib_fix ? ah_i + 8'h01 : ah_i;
        flags_o[F_AF] = nib_fix;
        flags_o[F_CF] = nib_fix;
        vld_o[F_AF]   = 1'b1;
        vld_o[F_CF]   = 1'b1;
      end
      OP_UP_SUB: begin
        // second borrow when the low byte itself underflows
        al_o          = nib_fix ? ((al_i - 8'h06) & 8'h0F) : (al_i & 8'h0F);
        ah_o          = nib_fix ? ah_i - 8'h01 - {7'd0, al_i < 8'h06} : ah_i;
        flags_o[F_AF] = nib_fix;
        flags_o[F_CF] = nib_fix;
        vld_o[F_AF]   = 1'b1;
        vld_o[F_CF]   = 1'b1;
      end
      OP_FOLD: begin
        al_o          = sum[BYTE_W-1:0];
        ah_o          = '0;
        flags_o[F_AF] = prod[3] ^ sum[3];
        flags_o[F_CF] = (sum > 16'h00FF);
        flags_o[F_OF] = sum[7] ^ al_i[7];
        flags_o[F_SF] = sum[7];
        flags_o[F_ZF] = (sum[BYTE_W-1:0] == '0);
        flags_o[F_PF] = even_par(sum[BYTE_W-1:0]);
        vld_o         = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_base_div.sv
module bcd_base_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quot_q, rem_q, dvs_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {rem_q, quot_q[W-1]};
  assign fits  = (trial >= {1'b0, dvs_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q <= '0; rem_q <= '0; dvs_q <= '0; dvd_q <= '0;
      cnt_q  <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        quot_q <= dvd_i;
        dvd_q  <= dvd_i;
        dvs_q  <= dvs_i;
        rem_q  <= '0;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
        quot_q <= {quot_q[W-2:0], fits};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quot_q;
  assign rem_o  = rem_q;

  // R7
  div_rem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rem_o < dvs_q));
  // R7
  div_identity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((2*W)'(quot_o) * (2*W)'(dvs_q) + (2*W)'(rem_o) == (2*W)'(dvd_q)));
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [2:0]  op_i,
  input  logic [7:0]  al_i,
  input  logic [7:0]  ah_i,
  input  logic        af_i,
  input  logic        cf_i,
  input  logic [7:0]  base_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  al_o,
  output logic [7:0]  ah_o,
  output logic [5:0]  flags_o,
  output logic [5:0]  flags_vld_o,
  output logic        div_err_o
);
  logic [BYTE_W-1:0] c_al, c_ah, d_quot, d_rem;
  logic [FLAG_N-1:0] c_fl, c_vl;
  logic              d_busy, d_done, accept, kick;
  logic [BYTE_W-1:0] al_q, ah_q;
  logic [FLAG_N-1:0] fl_q, vl_q;
  logic              done_q, err_q;
  logic [2:0]        op_q;

  bcd_adjust_core u_core (
    .op_i(op_i), .al_i(al_i), .ah_i(ah_i), .af_i(af_i), .cf_i(cf_i),
    .base_i(base_i), .al_o(c_al), .ah_o(c_ah), .flags_o(c_fl), .vld_o(c_vl)
  );

  assign busy_o = d_busy | d_done;
  assign accept = start_i & ~busy_o;
  assign kick   = accept & (op_i == OP_SPLIT) & (base_i != '0);

  bcd_base_div #(.W(BYTE_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(kick), .dvd_i(al_i),
    .dvs_i(base_i), .busy_o(d_busy), .done_o(d_done),
    .quot_o(d_quot), .rem_o(d_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      al_q <= '0; ah_q <= '0; fl_q <= '0; vl_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; op_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (d_done) begin
        al_q          <= d_rem;
        ah_q          <= d_quot;
        fl_q          <= '0;
        fl_q[F_SF]    <= d_rem[7];
        fl_q[F_ZF]    <= (d_rem == '0);
        fl_q[F_PF]    <= even_par(d_rem);
        vl_q          <= '0;
        vl_q[F_SF]    <= 1'b1;
        vl_q[F_ZF]    <= 1'b1;
        vl_q[F_PF]    <= 1'b1;
        err_q         <= 1'b0;
        done_q        <= 1'b1;
      end else if (accept) begin
        op_q <= op_i;
        if (!kick) begin
          al_q   <= c_al;
          ah_q   <= c_ah;
          fl_q   <= c_fl;
          vl_q   <= c_vl;
          err_q  <= (op_i == OP_SPLIT);
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o      = done_q;
  assign al_o        = al_q;
  assign ah_o        = ah_q;
  assign flags_o     = fl_q;
  assign flags_vld_o = vl_q;
  assign div_err_o   = err_q;

  // R2
  quick_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !kick) |=> done_o);
  // R11
  masked_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((flags_o & ~flags_vld_o) == '0));
  // R8
  zero_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_err_o) |-> (flags_vld_o == '0 && op_q == OP_SPLIT));
  // R9
  fold_ah_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_FOLD) |-> (ah_o == '0));
  // R12
  busy_no_kick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_busy && start_i) |=> !$rose(done_o) || $past(d_done));
endmodule

// File: tb/bcd_adjust_unit_tb_top.sv
module bcd_adjust_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] al = '0, ah = '0, base = '0;
  logic       af = 1'b0, cf = 1'b0;
  logic       busy, done, derr;
  logic [7:0] al_r, ah_r;
  logic [5:0] fl_r, vl_r;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [7:0] al;
    logic [7:0] ah;
    logic [5:0] fl;
    logic [5:0] vl;
    logic       err;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  bcd_adjust_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .al_i(al),
    .ah_i(ah), .af_i(af), .cf_i(cf), .base_i(base), .busy_o(busy),
    .done_o(done), .al_o(al_r), .ah_o(ah_r), .flags_o(fl_r),
    .flags_vld_o(vl_r), .div_err_o(derr)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit even_ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  // bit order: CF0 PF1 AF2 ZF3 SF4 OF5 (R2)
  function automatic exp_t model(input int o, input int a, input int h,
                                 input bit fa, input bit fc, input int b);
    exp_t e;
    bit lo, hi;
    int t, p, s;
    e = '0;
    e.al = a[7:0];
    e.ah = h[7:0];
    lo = ((a % 16) > 9) || fa;
    case (o)
      0: begin
        t  = lo ? (a + 6) % 256 : a;
        hi = (t > 159) || fc;
        t  = hi ? (t + 96) % 256 : t;
        e.al = t[7:0];
        e.fl = {1'b0, t >= 128, t == 0, lo, 1'b0, hi};
        e.vl = 6'b011101;
      end
      1: begin
        t  = lo ? (a + 256 - 6) % 256 : a;
        hi = (t > 159) || fc;
        t  = hi ? (t + 256 - 96) % 256 : t;
        e.al = t[7:0];
        e.fl = {3'b000, lo, 1'b0, hi};
        e.vl = 6'b000101;
      end
      2: begin
        e.al = lo ? 8'((a + 6) % 16) : 8'(a % 16);
        e.ah = lo ? 8'((h + 1) % 256) : h[7:0];
        e.fl = {3'b000, lo, 1'b0, lo};
        e.vl = 6'b000101;
      end
      3: begin
        t = h;
        if (lo) t = (a < 6) ? h + 512 - 2 : h + 512 - 1;
        e.ah = 8'(t % 256);
        e.al = lo ? 8'((a + 256 - 6) % 16) : 8'(a % 16);
        e.fl = {3'b000, lo, 1'b0, lo};
        e.vl = 6'b000101;
      end
      4: begin
        if (b == 0) e.err = 1'b1;
        else begin
          e.ah = 8'(a / b);
          e.al = 8'(a % b);
          e.fl = {1'b0, e.al >= 128, e.al == 0, 1'b0, even_ones(a % b), 1'b0};
          e.vl = 6'b011010;
        end
      end
      5: begin
        p = h * b;
        s = p + a;
        e.al = 8'(s % 256);
        e.ah = 8'h00;
        e.fl = {((s >> 7) & 1) != ((a >> 7) & 1), (s % 256) >= 128,
                (s % 256) == 0, ((p >> 3) & 1) != ((s >> 3) & 1),
                even_ones(s % 256), s > 255};
        e.vl = 6'b111111;
      end
      default: ;
    endcase
    return e;
  endfunction

  // monitor: pop and compare on every completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check("R12 unexpected completion", 1, 0);
      end else begin
        exp_t  e;
        string tg;
        e  = sb_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, {al_r, ah_r, fl_r, vl_r, derr}, e);
      end
    end
  end

  task automatic issue(input int o, input int a, input int h, input bit fa,
                       input bit fc, input int b, input string tag,
                       input bit intrude = 1'b0);
    sb_q.push_back(model(o, a, h, fa, fc, b));
    tag_q.push_back(tag);
    op = 3'(o); al = 8'(a); ah = 8'(h); af = fa; cf = fc; base = 8'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (o != 4 || b == 0) check("R2 one-cycle completion", done, 1);
    if (intrude && busy) begin
      op = 3'd0; al = 8'h99; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 err", derr, 0);
    check("R1 al/ah", {al_r, ah_r}, 0);
    check("R1 mask", vl_r, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 packed add
    issue(0, 'h9A, 'h11, 0, 0, 0, "R3 both fixes, zero");
    issue(0, 'h15, 'h22, 0, 0, 0, "R3 no fix");
    issue(0, 'h12, 'h00, 1, 0, 0, "R3 af forced");
    issue(0, 'h05, 'h00, 0, 1, 0, "R3 cf forced");
    // R4 packed subtract
    issue(1, 'h0F, 'h00, 0, 1, 0, "R4 both fixes");
    issue(1, 'h03, 'h00, 1, 0, 0, "R4 wrap");
    issue(1, 'h42, 'h00, 0, 0, 0, "R4 no fix");
    // R5 unpacked add
    issue(2, 'h0B, 'h01, 0, 0, 0, "R5 fix");
    issue(2, 'hFA, 'hFF, 0, 0, 0, "R5 wrap both");
    issue(2, 'h37, 'h04, 0, 0, 0, "R5 no fix mask");
    // R6 unpacked subtract
    issue(3, 'h03, 'h05, 1, 0, 0, "R6 double borrow");
    issue(3, 'h2F, 'h05, 0, 0, 0, "R6 single borrow");
    issue(3, 'h35, 'h05, 0, 0, 0, "R6 no fix");
    issue(3, 'h00, 'h01, 1, 0, 0, "R6 ah underflow");
    // R7 split by base
    issue(4, 'h4F, 'h00, 0, 0, 10, "R7 base ten");
    issue(4, 'hFF, 'h33, 0, 0, 'hFF, "R7 base max");
    issue(4, 'h80, 'h00, 0, 0, 1, "R7 base one");
    issue(4, 'hC7, 'h00, 0, 0, 'h10, "R7 base sixteen");
    // R7 latency bound
    sb_q.push_back(model(4, 'h63, 0, 0, 0, 7));
    tag_q.push_back("R7 latency result");
    op = 3'd4; al = 8'h63; base = 8'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    check("R7 latency within 10", lat <= 10, 1);
    @(negedge clk);
    // R8 zero base
    issue(4, 'h5A, 'hA5, 1, 1, 0, "R8 zero base");
    // R9 / R10 fold by base
    issue(5, 'h09, 'h07, 0, 0, 10, "R9 fold ten");
    issue(5, 'hFF, 'hFF, 0, 0, 'hFF, "R9 fold carry");
    issue(5, 'h80, 'h00, 0, 0, 10, "R10 fold no change");
    issue(5, 'h70, 'h01, 0, 0, 'h20, "R10 fold sign flip");
    // R11 reserved codes
    issue(6, 'h12, 'h34, 1, 1, 3, "R11 reserved six");
    issue(7, 'hAB, 'hCD, 0, 1, 3, "R11 reserved seven");
    // R12 start during split
    issue(4, 'hEE, 'h00, 0, 0, 3, "R12 split with intrusion", 1'b1);
    @(negedge clk);
    check("R12 no extra result", done, 0);
    check("R12 scoreboard empty", sb_q.size(), 0);
    // mixed sweep, R11 parity through all ops
    for (int k = 0; k < 60; k++) begin
      int o = k % 8;
      issue(o, $urandom_range(255), $urandom_range(255), 1'($urandom_range(1)),
            1'($urandom_range(1)), $urandom_range(255), "R11 sweep");
    end
    repeat (2) @(negedge clk);
    check("scoreboard drained", sb_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule